// File: doc/BRIEF.md
# Quantum-Limited Two-Port Bus Arbiter

This block shares one internal bus between a receive engine and a transmit engine. Each engine raises a request when it has data to move. The arbiter answers with a grant and keeps it for at most a fixed slice of clock cycles. The default slice is 32 cycles, which is enough to move 128 bytes over a 32-bit path. An engine that finishes early raises its done input, and the grant is taken back on the next edge. An engine that withdraws its request is treated the same way.

Between clients, turns alternate round robin. The receive side is favoured whenever there is no history to go on. A single requester is granted again without waiting for the other client. Every grant is followed by at least one cycle in which nobody owns the bus, which serves as turnaround.

Top module: `qarb_top`

## Requirements
- R1: While synchronous active-high `rst` is sampled high, both grants are low on the following cycle. The last-owner record is cleared to none, so after reset both clients requesting together results in a receive grant.
- R2: At most one grant is high in any cycle. A grant to one client is never followed directly by a grant to the other client without an idle cycle between them.
- R3: A grant rises only if that client's request was high in the previous cycle. A done input seen while no grant is held has no effect. A lone request seen in an idle cycle gives that client the grant on the next cycle.
- R4: With its request held and done low, a holder keeps the grant for exactly `SLICE_CYCLES` consecutive cycles (default 32) and then loses it.
- R5: A holder that raises done loses its grant in the next cycle.
- R6: A holder whose request is low while it holds the grant loses its grant in the next cycle.
- R7: When both clients request in an idle cycle and there is no last owner, receive is granted.
- R8: When both clients request in an idle cycle, the client that was not the last owner is granted.
- R9: When only one client requests in an idle cycle, it is granted even if it was the last owner. The grant follows a single idle cycle after its previous grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 1 | Receive engine wants the bus |
| rx_done | input | 1 | Receive engine releases the bus early |
| tx_req | input | 1 | Transmit engine wants the bus |
| tx_done | input | 1 | Transmit engine releases the bus early |
| rx_gnt | output | 1 | Receive engine owns the bus |
| tx_gnt | output | 1 | Transmit engine owns the bus |

## Verification
The assertions assume that the request and done inputs are synchronous to `clk` and stable around each rising edge. They also assume that reset is held for at least one edge before any checks start. No assumption is made about done arriving without a grant: that case is legal input and has no effect. The stimulus changes every input on the falling edge only and starts with reset held high. It deliberately raises done while idle and drops requests mid-grant, so that these input combinations are exercised as well.

// File: rtl/qarb_pkg.sv
package qarb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_RX   = 2'd1,
        OWN_TX   = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e holder;
        owner_e prev;
    } arb_state_t;

endpackage

// File: rtl/qarb_pick.sv
module qarb_pick
    import qarb_pkg::*;
(
    input  logic   rx_want,
    input  logic   tx_want,
    input  owner_e prev,
    output owner_e winner
);
    always_comb begin
        winner = OWN_NONE;
        if (rx_want && tx_want) begin
            // alternate; receive wins when there is no history or tx went last
            winner = (prev == OWN_RX) ? OWN_TX : OWN_RX;
        end else if (rx_want) begin
            winner = OWN_RX;
        end else if (tx_want) begin
            winner = OWN_TX;
        end
    end
endmodule

// File: rtl/qarb_slice.sv
module qarb_slice #(
    parameter int SLICE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic last_cycle
);
    localparam int CW = (SLICE_CYCLES > 2) ? $clog2(SLICE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLICE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_cycle = (cnt_q == LAST);
endmodule

// File: rtl/qarb_top.sv
module qarb_top
    import qarb_pkg::*;
#(
    parameter int SLICE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_req,
    input  logic rx_done,
    input  logic tx_req,
    input  logic tx_done,
    output logic rx_gnt,
    output logic tx_gnt
);
    arb_state_t st_d, st_q;
    owner_e     pick;
    logic       start_slice;
    logic       slice_end;

    qarb_pick u_pick (
        .rx_want (rx_req),
        .tx_want (tx_req),
        .prev    (st_q.prev),
        .winner  (pick)
    );

    qarb_slice #(.SLICE_CYCLES(SLICE_CYCLES)) u_slice (
        .clk        (clk),
        .rst        (rst),
        .load       (start_slice),
        .last_cycle (slice_end)
    );

    always_comb begin
        st_d        = st_q;
        start_slice = 1'b0;
        unique case (st_q.holder)
            OWN_NONE: begin
                if (pick != OWN_NONE) begin
                    st_d.holder = pick;
                    start_slice = 1'b1;
                end
            end
            OWN_RX: begin
                if (rx_done || !rx_req || slice_end) begin
                    st_d.holder = OWN_NONE;
                    st_d.prev   = OWN_RX;
                end
            end
            OWN_TX: begin
                if (tx_done || !tx_req || slice_end) begin
                    st_d.holder = OWN_NONE;
                    st_d.prev   = OWN_TX;
                end
            end
            default: begin
                st_d.holder = OWN_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.holder <= OWN_NONE;
            st_q.prev   <= OWN_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_gnt = (st_q.holder == OWN_RX);
    assign tx_gnt = (st_q.holder == OWN_TX);
endmodule

// File: rtl/qarb_chk.sv
module qarb_chk #(
    parameter int SLICE_CYCLES = 32
) (
    input logic clk,
    input logic rst,
    input logic rx_req,
    input logic rx_done,
    input logic tx_req,
    input logic tx_done,
    input logic rx_gnt,
    input logic tx_gnt
);
    localparam int RW = $clog2(SLICE_CYCLES + 2) + 1;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (rx_gnt || tx_gnt) begin
            run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (!rx_gnt && !tx_gnt));

    // R2
    one_hot_chk: assert property (@(posedge clk) disable iff (rst) !(rx_gnt && tx_gnt));

    // R2
    rx_to_tx_gap_chk: assert property (@(posedge clk) disable iff (rst) rx_gnt |=> !tx_gnt);

    // R2
    tx_to_rx_gap_chk: assert property (@(posedge clk) disable iff (rst) tx_gnt |=> !rx_gnt);

    // R3
    rx_needs_req_chk: assert property (@(posedge clk) disable iff (rst) $rose(rx_gnt) |-> $past(rx_req));

    // R3
    tx_needs_req_chk: assert property (@(posedge clk) disable iff (rst) $rose(tx_gnt) |-> $past(tx_req));

    // R4
    slice_limit_chk: assert property (@(posedge clk) disable iff (rst) run_q <= RW'(SLICE_CYCLES));

    // R5
    rx_done_release_chk: assert property (@(posedge clk) disable iff (rst) (rx_gnt && rx_done) |=> !rx_gnt);

    // R5
    tx_done_release_chk: assert property (@(posedge clk) disable iff (rst) (tx_gnt && tx_done) |=> !tx_gnt);

    // R6
    rx_drop_release_chk: assert property (@(posedge clk) disable iff (rst) (rx_gnt && !rx_req) |=> !rx_gnt);

    // R6
    tx_drop_release_chk: assert property (@(posedge clk) disable iff (rst) (tx_gnt && !tx_req) |=> !tx_gnt);
endmodule

bind qarb_top qarb_chk #(.SLICE_CYCLES(SLICE_CYCLES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rx_req  (rx_req),
    .rx_done (rx_done),
    .tx_req  (tx_req),
    .tx_done (tx_done),
    .rx_gnt  (rx_gnt),
    .tx_gnt  (tx_gnt)
);

// File: tb/tb_qarb_top.sv
module tb_qarb_top;
    localparam int Q = 32;
    localparam int NV = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_req = 1'b0, rx_done = 1'b0, tx_req = 1'b0, tx_done = 1'b0;
    logic rx_gnt, tx_gnt;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    qarb_top #(.SLICE_CYCLES(Q)) dut (
        .clk(clk), .rst(rst),
        .rx_req(rx_req), .rx_done(rx_done),
        .tx_req(tx_req), .tx_done(tx_done),
        .rx_gnt(rx_gnt), .tx_gnt(tx_gnt)
    );

    // fields: {requirement[3:0], rx_req, rx_done, tx_req, tx_done, exp_rx, exp_tx}
    localparam logic [9:0] VEC [NV] = '{
        {4'd1, 6'b0000_00}, // R1 idle after reset
        {4'd7, 6'b1010_10}, // R7 both request, no history -> rx
        {4'd7, 6'b1010_10}, // R7 rx holds
        {4'd5, 6'b1110_00}, // R5 rx done -> released
        {4'd8, 6'b1010_01}, // R8 rx went last -> tx
        {4'd8, 6'b1010_01}, // R8 tx holds
        {4'd6, 6'b1000_00}, // R6 tx drops request -> released
        {4'd8, 6'b1000_10}, // R8 rx alone after tx
        {4'd8, 6'b1000_10}, // R8 rx holds
        {4'd5, 6'b1100_00}, // R5 rx done
        {4'd9, 6'b1000_10}, // R9 rx regranted though last owner
        {4'd6, 6'b0000_00}, // R6 rx drops request
        {4'd3, 6'b0101_00}, // R3 done while idle ignored
        {4'd3, 6'b0010_01}, // R3 lone tx request granted
        {4'd5, 6'b0011_00}, // R5 tx done
        {4'd8, 6'b1010_10}, // R8 tx went last -> rx
        {4'd6, 6'b0010_00}  // R6 rx drops, tx waits for gap
    };

    task automatic step(input logic rr, input logic rd, input logic tr, input logic td,
                        input logic er, input logic et, input int rq);
        rx_req = rr; rx_done = rd; tx_req = tr; tx_done = td;
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (rx_gnt !== er || tx_gnt !== et) begin
            n_bad++;
            $display("FAIL R%0d: rx_gnt/tx_gnt = %b%b, expected %b%b", rq, rx_gnt, tx_gnt, er, et);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset held with both requesting
        step(1, 0, 1, 0, 0, 0, 1);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], int'(VEC[i][9:6]));
        end
        // last owner is rx; both request: tx, then full slices (R4)
        for (int i = 0; i < Q; i++) step(1, 0, 1, 0, 0, 1, 4);
        step(1, 0, 1, 0, 0, 0, 4);
        for (int i = 0; i < Q; i++) step(1, 0, 1, 0, 1, 0, 4);
        step(1, 0, 1, 0, 0, 0, 4);
        step(1, 0, 1, 0, 0, 1, 8);
        // R1: reset in mid-grant clears grant and history
        rst = 1'b1;
        step(1, 0, 1, 0, 0, 0, 1);
        rst = 1'b0;
        step(1, 0, 1, 0, 1, 0, 1);
        // R4: lone requester is cut at the slice, then regranted (R9)
        for (int i = 1; i < Q; i++) step(1, 0, 0, 0, 1, 0, 4);
        step(1, 0, 0, 0, 0, 0, 4);
        step(1, 0, 0, 0, 1, 0, 9);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule